// File: doc/BRIEF.md
# Sample Stream Port Demultiplexer

This block receives one 10-bit converter sample per clock, together with an over-range bit, and spreads consecutive samples over four output ports, A to D. A ratio input selects whether a group holds four samples, spread over all four ports, or two samples, spread over A and B only. The block can also Gray-code each sample before it is spread. A built-in self-test replaces live data with a fixed alternating checkerboard.

The ports can update in two ways. In simultaneous mode, all active ports change together when a group is complete, and each port's flag bit carries the over-range bit of its own sample. In staggered mode, each port loads as soon as its own sample arrives, and the flag bits become per-port data-ready strobes. A shared `rdy` strobe marks each output word. It either pulses on the word, for full-rate capture on the rising edge, or toggles on the word, for half-rate capture on both edges. An active-low alignment input clears the strobes and restarts the group, so that the next sample is known to land on port A. A sleep input freezes the whole block.

Top module: `sample_demux`

## Requirements
- R1: While `rst_n` is low, `q_data`, `q_flag` and `rdy` are all zero.
- R2: With `ratio4`=1, `stagger`=0 and `bist`=0, the samples seen at the first four active clock edges after `drr_n` rises go to ports A, B, C and D in that order. Port k sits in `q_data[10k+9:10k]`, with A as k=0. All four ports change together at the edge that captures the fourth sample, and not before.
- R3: With `ratio4`=0 and `bist`=0, pairs of samples go to A then B. Ports C and D and their flag bits do not change.
- R4: With `stagger`=0, `q_flag[k]` takes the `ovr` value that arrived with port k's sample, when that port loads.
- R5: With `stagger`=1 and `bist`=0, port k loads its sample at the edge that captures it, which is k edges after port A. No other port changes at that edge.
- R6: With `stagger`=1, `q_flag[k]` is port k's data-ready strobe. With `half_rate`=0 it is high for exactly the cycle after each load of that port. With `half_rate`=1 it toggles at each load of that port.
- R7: With `half_rate`=0, `rdy` is high for the one cycle after each word. A word is a group completion in simultaneous mode, or a load of port A in staggered mode.
- R8: With `half_rate`=1, `rdy` toggles once per word, using the same word definition as R7.
- R9: With `bist`=1, every group completion loads all four ports with a checkerboard. On the first load after self-test is entered, A, B and D get 1010101010 (MSB first) and C gets 0101010101. Each later load inverts every port. This applies at either ratio.
- R10: With `gray`=1, each output sample is b ^ (b >> 1) of the input sample b.
- R11: While `drr_n` is low at an edge, `rdy` is cleared, the group restarts at port A, and in staggered mode `q_flag` is cleared. `q_data` does not change.
- R12: While `sleep`=1 (with `drr_n` high), outputs, strobes and group position are frozen, and the samples presented are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drr_n | input | 1 | Strobe reset and group alignment, active low |
| ratio4 | input | 1 | 1: four-port groups; 0: two-port groups |
| stagger | input | 1 | 1: staggered port loading; 0: simultaneous |
| half_rate | input | 1 | 1: strobes toggle per word; 0: strobes pulse |
| bist | input | 1 | Self-test checkerboard enable |
| gray | input | 1 | Gray-code output samples |
| sleep | input | 1 | Freeze all updates |
| smp | input | W | Input sample |
| ovr | input | 1 | Over-range bit of the input sample |
| q_data | output | 4*W | Port data, port k in bits 10k+9:10k |
| q_flag | output | 4 | Over-range bits (simultaneous) or per-port strobes (staggered) |
| rdy | output | 1 | Common data-ready strobe |

## Verification
The hardest situation to reach is a group that is interrupted part-way: sleep asserted after only some of a group's samples have been captured. The bench reaches it by pulsing `drr_n` to fix the group position and feeding two samples. It then holds `sleep` for several cycles while presenting a different sample, and finally feeds the last two samples. The order of the four resulting ports shows whether sleep dropped or absorbed any sample. The staggered strobes are checked in a similar way. After an alignment pulse, the bench samples one edge per port and checks that only the expected port and its strobe moved.

// File: rtl/sample_demux.sv
module sample_demux #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           drr_n,
  input  logic           ratio4,
  input  logic           stagger,
  input  logic           half_rate,
  input  logic           bist,
  input  logic           gray,
  input  logic           sleep,
  input  logic [W-1:0]   smp,
  input  logic           ovr,
  output logic [4*W-1:0] q_data,
  output logic [3:0]     q_flag,
  output logic           rdy
);

  function automatic logic [W-1:0] checker_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = ((W - 1 - i) % 2) == 0;
    return v;
  endfunction

  localparam logic [W-1:0] PAT = checker_word();

  logic [1:0]   ph;
  logic [1:0]   last;
  logic         grp_end, evt, bcyc;
  logic [W-1:0] code;
  logic [W-1:0] shd [4];
  logic [3:0]   shd_ovr;
  logic [3:0]   ld;
  logic [W-1:0] nxt [4];
  logic [3:0]   nxt_ovr;

  assign last    = ratio4 ? 2'd3 : 2'd1;
  assign grp_end = ph >= last;
  assign code    = gray ? (smp ^ (smp >> 1)) : smp;
  assign evt     = (stagger && !bist) ? (ph == 2'd0) : grp_end;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      if (bist) begin
        ld[k]      = grp_end;
        nxt[k]     = ((k == 2) ? ~PAT : PAT) ^ {W{bcyc}};
        nxt_ovr[k] = 1'b0;
      end else if (stagger) begin
        ld[k]      = (2'(k) <= last) && (ph == 2'(k));
        nxt[k]     = code;
        nxt_ovr[k] = ovr;
      end else begin
        ld[k]      = (2'(k) <= last) && grp_end;
        nxt[k]     = (2'(k) == last) ? code : shd[k];
        nxt_ovr[k] = (2'(k) == last) ? ovr : shd_ovr[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      bcyc    <= 1'b0;
      rdy     <= 1'b0;
      q_data  <= '0;
      q_flag  <= '0;
      shd_ovr <= '0;
      for (int k = 0; k < 4; k++) shd[k] <= '0;
    end else if (!drr_n) begin
      ph  <= '0;
      rdy <= 1'b0;
      if (stagger) q_flag <= '0;
    end else if (!sleep) begin
      ph   <= grp_end ? 2'd0 : ph + 2'd1;
      rdy  <= half_rate ? (rdy ^ evt) : evt;
      bcyc <= bist ? (bcyc ^ grp_end) : 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (ph == 2'(k)) begin
          shd[k]     <= code;
          shd_ovr[k] <= ovr;
        end
        if (ld[k]) q_data[k*W +: W] <= nxt[k];
        if (stagger)
          q_flag[k] <= half_rate ? (q_flag[k] ^ ld[k]) : ld[k];
        else if (ld[k])
          q_flag[k] <= nxt_ovr[k];
      end
    end
  end

endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk #(
  parameter int W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           drr_n,
  input logic           ratio4,
  input logic           stagger,
  input logic           bist,
  input logic           sleep,
  input logic [1:0]     ph,
  input logic [4*W-1:0] q_data,
  input logic           rdy
);

  logic [1:0]   lst;
  logic [W-1:0] pa, pb, pc, pd;
  assign lst = ratio4 ? 2'd3 : 2'd1;
  assign pa = q_data[0 +: W];
  assign pb = q_data[W +: W];
  assign pc = q_data[2*W +: W];
  assign pd = q_data[3*W +: W];

  AST_ALIGN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !drr_n |=> (!rdy && $stable(q_data))); // R11

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && drr_n) |=> ($stable(q_data) && $stable(rdy))); // R12

  AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ratio4 && !bist) |=> $stable(q_data[4*W-1:2*W])); // R3

  AST_STAGGER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stagger && !bist) |=> $onehot0({pa != $past(pa), pb != $past(pb),
                                     pc != $past(pc), pd != $past(pd)})); // R5

  AST_BIST_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (bist && drr_n && !sleep && ph >= lst) |=>
      (pa == pb && pa == pd && pc == ~pa && pa[W-1:1] == ~pa[W-2:0])); // R9

endmodule

bind sample_demux sample_demux_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drr_n(drr_n), .ratio4(ratio4),
  .stagger(stagger), .bist(bist), .sleep(sleep), .ph(ph),
  .q_data(q_data), .rdy(rdy)
);

// File: tb/sample_demux_test.sv
module sample_demux_test;
  logic clk = 1'b0, rst_n = 1'b0, drr_n = 1'b1;
  logic ratio4 = 1'b1, stagger = 1'b0, half_rate = 1'b0, bist = 1'b0;
  logic gray = 1'b0, sleep = 1'b0, ovr = 1'b0;
  logic [9:0]  smp = '0;
  logic [39:0] q_data;
  logic [3:0]  q_flag;
  logic        rdy;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  sample_demux uut (.clk(clk), .rst_n(rst_n), .drr_n(drr_n), .ratio4(ratio4),
    .stagger(stagger), .half_rate(half_rate), .bist(bist), .gray(gray),
    .sleep(sleep), .smp(smp), .ovr(ovr), .q_data(q_data), .q_flag(q_flag), .rdy(rdy));

  // {ratio4, gray, base, ovr per sample, expected {D,C,B,A}, expected flags}
  localparam logic [59:0] VEC [4] = '{
    {1'b1, 1'b0, 10'h010, 4'b0101, 10'h013, 10'h012, 10'h011, 10'h010, 4'b0101},
    {1'b1, 1'b1, 10'h2F0, 4'b1010, 10'h38A, 10'h38B, 10'h389, 10'h388, 4'b1010},
    {1'b0, 1'b0, 10'h155, 4'b0001, 10'h38A, 10'h38B, 10'h156, 10'h155, 4'b1001},
    {1'b0, 1'b1, 10'h3FF, 4'b0010, 10'h38A, 10'h38B, 10'h000, 10'h200, 4'b1010}
  };

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic feed(input logic [9:0] s, input logic o);
    smp = s; ovr = o;
    @(negedge clk);
  endtask

  task automatic align();
    drr_n = 1'b0;
    @(negedge clk);
    drr_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 reset data", q_data, '0);
    chk("R1 reset flags/rdy", {35'd0, q_flag, rdy}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      ratio4 = VEC[i][59]; gray = VEC[i][58];
      align();
      for (int j = 0; j < (VEC[i][59] ? 4 : 2); j++)
        feed(VEC[i][57:48] + 10'(j), VEC[i][44 + j]);
      chk("R2 R3 R10 port data", q_data, VEC[i][43:4]);
      chk("R4 over-range flags", {36'd0, q_flag}, {36'd0, VEC[i][3:0]});
      chk("R7 rdy pulse", {39'd0, rdy}, 40'd1);
      @(negedge clk);
      chk("R7 rdy one cycle", {39'd0, rdy}, 40'd0);
    end

    ratio4 = 1'b1; gray = 1'b0;
    align();
    prev = q_data;
    feed(10'h0A0, 1'b0);
    feed(10'h0A1, 1'b0);
    chk("R2 no update mid-group", q_data, prev);
    sleep = 1'b1;
    for (int j = 0; j < 3; j++) feed(10'h3C0, 1'b1);
    chk("R12 sleep holds data", q_data, prev);
    chk("R12 sleep holds rdy", {39'd0, rdy}, 40'd0);
    sleep = 1'b0;
    feed(10'h0A2, 1'b0);
    feed(10'h0A3, 1'b0);
    chk("R12 order kept across sleep", q_data, {10'h0A3, 10'h0A2, 10'h0A1, 10'h0A0});

    bist = 1'b1; ratio4 = 1'b0;
    align();
    feed(10'h001, 1'b0);
    feed(10'h002, 1'b0);
    chk("R9 bist cycle 0", q_data, {10'h2AA, 10'h155, 10'h2AA, 10'h2AA});
    feed(10'h003, 1'b0);
    feed(10'h004, 1'b0);
    chk("R9 bist cycle 1", q_data, {10'h155, 10'h2AA, 10'h155, 10'h155});
    bist = 1'b0; ratio4 = 1'b1; stagger = 1'b1;

    align();
    prev = q_data;
    feed(10'h100, 1'b0);
    chk("R5 stagger A only", q_data, {prev[39:10], 10'h100});
    chk("R6 strobe A", {36'd0, q_flag}, 40'h1);
    chk("R7 rdy on A load", {39'd0, rdy}, 40'd1);
    feed(10'h101, 1'b0);
    chk("R5 stagger B", q_data, {prev[39:20], 10'h101, 10'h100});
    chk("R6 strobe B", {36'd0, q_flag}, 40'h2);
    feed(10'h102, 1'b0);
    feed(10'h103, 1'b0);
    chk("R5 stagger D", q_data, {10'h103, 10'h102, 10'h101, 10'h100});
    chk("R6 strobe D", {36'd0, q_flag}, 40'h8);
    feed(10'h104, 1'b0);
    prev = q_data;
    drr_n = 1'b0;
    @(negedge clk);
    chk("R11 align holds data", q_data, prev);
    chk("R11 align clears strobes", {35'd0, q_flag, rdy}, '0);
    drr_n = 1'b1;

    half_rate = 1'b1;
    for (int j = 0; j < 4; j++) feed(10'h200 + 10'(j), 1'b0);
    chk("R6 half-rate strobes toggled", {36'd0, q_flag}, 40'hF);
    chk("R8 stagger rdy toggled", {39'd0, rdy}, 40'd1);
    feed(10'h204, 1'b0);
    feed(10'h205, 1'b0);
    chk("R6 half-rate A B back", {36'd0, q_flag}, 40'hC);
    chk("R8 stagger rdy back", {39'd0, rdy}, 40'd0);

    stagger = 1'b0;
    align();
    for (int j = 0; j < 4; j++) feed(10'h300, 1'b0);
    chk("R8 half-rate rdy high", {39'd0, rdy}, 40'd1);
    for (int j = 0; j < 4; j++) feed(10'h301, 1'b0);
    chk("R8 half-rate rdy low", {39'd0, rdy}, 40'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule